// File: doc/BRIEF.md
# Monitor Mode Entry Controller

This block decides, once per power-on, whether the device comes up in its serial monitor mode and how the clocks are set up for that session. When the power-on reset is released, it looks at the level on the interrupt pin, the PTC3 pin and the two reset-vector bytes. From these it picks one of three entry paths, or normal operation, and keeps that choice until the next power-on reset.

A vector is blank only when both bytes read all ones. A programmed vector needs the test high voltage on the interrupt pin to enter monitor mode. In that case PTC3 selects between an oscillator bypass with the input clock divided by two, and the input clock divided by four. A blank vector enters monitor mode from either the normal high or the low interrupt level. The low level also enables the PLL, which multiplies a 32.768 kHz crystal up to a 2.4576 MHz bus clock. Both blank-vector paths ask the reset logic for one extra internal reset after power-on. The watchdog disable is held for the whole session on the blank-vector paths. On the test-voltage path it follows the live high-voltage condition on the interrupt or reset pin.

Top module: `mon_entry_ctrl`

## Requirements
- R1: The vector counts as blank only when `vec_hi` and `vec_lo` are both all ones. Any other value, for example 0xFF with 0xFE, counts as programmed.
- R2: With `irq_lvl` = 2'b10 (test voltage), monitor mode is entered with `pll_en` low, whether the vector is blank or programmed.
- R3: On the test-voltage path, a latched PTC3 low gives `osc_bypass`=1 and `bus_div4`=0. A latched PTC3 high gives `osc_bypass`=0 and `bus_div4`=1.
- R4: A blank vector with `irq_lvl` 2'b01 or 2'b11 (normal high) gives `mon_mode`=1, `pll_en`=0, `osc_bypass`=0 and `bus_div4`=1, whatever the level on PTC3.
- R5: A blank vector with `irq_lvl` = 2'b00 (low) gives `mon_mode`=1, `pll_en`=1, `osc_bypass`=0 and `bus_div4`=1, whatever the level on PTC3.
- R6: A programmed vector without the test voltage gives `mon_mode`=0, `pll_en`=0, `osc_bypass`=0, `bus_div4`=1, `cop_dis`=0 and `extra_rst_req`=0.
- R7: While `por_n` is low, and until the third rising clock edge after it rises, the outputs take the R6 values. The entry conditions are latched at that third edge. Later changes on the pins or the vector bytes do not alter `mon_mode`, `pll_en`, `osc_bypass` or `bus_div4`.
- R8: On the blank-vector paths, `extra_rst_req` is high for exactly PULSE_CYCLES cycles, starting right after the latching edge, once per power-on reset. On any other path it stays low.
- R9: On the blank-vector paths, `cop_dis` stays 1 for the whole session, whatever `irq_lvl` and `rst_pin_hv` do.
- R10: On the test-voltage path, `cop_dis` is 1 exactly while `irq_lvl` = 2'b10 or `rst_pin_hv` = 1. The inputs reach it without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| irq_lvl | input | 2 | Interrupt pin level: 00 low, 01 high, 10 test voltage, 11 high |
| rst_pin_hv | input | 1 | Test high voltage present on the reset pin |
| ptc3 | input | 1 | PTC3 pin level |
| vec_hi | input | VEC_W | Reset vector high byte |
| vec_lo | input | VEC_W | Reset vector low byte |
| mon_mode | output | 1 | Monitor mode active |
| pll_en | output | 1 | PLL enable |
| osc_bypass | output | 1 | Bypass the oscillator divide-by-two stage |
| bus_div4 | output | 1 | 1: bus = input/4, 0: bus = input/2 |
| cop_dis | output | 1 | Watchdog disable |
| extra_rst_req | output | 1 | Request for an extra internal reset |

## Verification
The bench builds the block with VEC_W = 8 and PULSE_CYCLES = 3. A pulse several cycles long makes an early end or a late start of the reset request show up as a mismatch on a single clock. Each power-on run first changes the pins and the vector bytes after the latching edge. It then turns the test voltage on and off on both the interrupt and the reset pin. This covers both the frozen clock setup and the live watchdog behaviour in one session. Vectors that are one bit short of blank check the blank test at its edge.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;

  typedef enum logic [1:0] {
    IRQ_LOW  = 2'b00,
    IRQ_HIGH = 2'b01,
    IRQ_TEST = 2'b10,
    IRQ_RSVD = 2'b11
  } irq_lvl_e;

  typedef enum logic [1:0] {
    PATH_NONE     = 2'd0,
    PATH_TEST     = 2'd1,
    PATH_BLANK_HI = 2'd2,
    PATH_BLANK_LO = 2'd3
  } entry_path_e;

  function automatic logic path_is_blank(entry_path_e p);
    return (p == PATH_BLANK_HI) || (p == PATH_BLANK_LO);
  endfunction

endpackage

// File: rtl/mon_path_decode.sv
module mon_path_decode
  import mon_entry_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic [1:0]       irq_lvl,
  input  logic [VEC_W-1:0] vec_hi,
  input  logic [VEC_W-1:0] vec_lo,
  output entry_path_e      path
);

  localparam int TOT_W = 2 * VEC_W;

  logic [TOT_W-1:0] vec_all;
  logic             blank;

  assign vec_all = {vec_hi, vec_lo};
  assign blank   = &vec_all;

  always_comb begin
    path = PATH_NONE;
    if (irq_lvl == IRQ_TEST) begin
      path = PATH_TEST;
    end else if (blank) begin
      path = (irq_lvl == IRQ_LOW) ? PATH_BLANK_LO : PATH_BLANK_HI;
    end
  end

endmodule

// File: rtl/mon_entry_latch.sv
module mon_entry_latch
  import mon_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  entry_path_e path_d,
  input  logic        ptc3_d,
  output logic        sampled_o,
  output logic        take_o,
  output entry_path_e path_o,
  output logic        ptc3_o
);

  logic        sampled_q, sampled_nx;
  entry_path_e path_q, path_nx;
  logic        ptc3_q, ptc3_nx;
  logic        take;

  assign take = !sampled_q;

  always_comb begin
    sampled_nx = sampled_q;
    path_nx    = path_q;
    ptc3_nx    = ptc3_q;
    if (take) begin
      sampled_nx = 1'b1;
      path_nx    = path_d;
      ptc3_nx    = ptc3_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampled_q <= 1'b0;
      path_q    <= PATH_NONE;
      ptc3_q    <= 1'b0;
    end else begin
      sampled_q <= sampled_nx;
      path_q    <= path_nx;
      ptc3_q    <= ptc3_nx;
    end
  end

  assign sampled_o = sampled_q;
  assign take_o    = take;
  assign path_o    = path_q;
  assign ptc3_o    = ptc3_q;

  // R7: the latched path holds once taken
  p_path_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sampled_q && $past(sampled_q)) |-> ($stable(path_q) && $stable(ptc3_q)));

endmodule

// File: rtl/mon_reset_pulse.sv
module mon_reset_pulse #(
  parameter int PULSE_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic req_o
);

  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (load_i) begin
      cnt_nx = CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_nx = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
    end
  end

  assign req_o = (cnt_q != '0);

  // R8: the request starts only on a load
  p_req_starts_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(load_i));

endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl
  import mon_entry_pkg::*;
#(
  parameter int VEC_W        = 8,
  parameter int PULSE_CYCLES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [1:0]       irq_lvl,
  input  logic             rst_pin_hv,
  input  logic             ptc3,
  input  logic [VEC_W-1:0] vec_hi,
  input  logic [VEC_W-1:0] vec_lo,
  output logic             mon_mode,
  output logic             pll_en,
  output logic             osc_bypass,
  output logic             bus_div4,
  output logic             cop_dis,
  output logic             extra_rst_req
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_s_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_s_n = rst_sync_q[SYNC_STAGES-1];

  entry_path_e path_d, path_q;
  logic        sampled, take, ptc3_q, load_pulse;

  mon_path_decode #(.VEC_W(VEC_W)) u_decode (
    .irq_lvl (irq_lvl),
    .vec_hi  (vec_hi),
    .vec_lo  (vec_lo),
    .path    (path_d)
  );

  mon_entry_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .path_d    (path_d),
    .ptc3_d    (ptc3),
    .sampled_o (sampled),
    .take_o    (take),
    .path_o    (path_q),
    .ptc3_o    (ptc3_q)
  );

  assign load_pulse = take && path_is_blank(path_d);

  mon_reset_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .load_i (load_pulse),
    .req_o  (extra_rst_req)
  );

  always_comb begin
    mon_mode   = 1'b0;
    pll_en     = 1'b0;
    osc_bypass = 1'b0;
    bus_div4   = 1'b1;
    cop_dis    = 1'b0;
    if (sampled) begin
      unique case (path_q)
        PATH_TEST: begin
          mon_mode   = 1'b1;
          osc_bypass = !ptc3_q;
          bus_div4   = ptc3_q;
          cop_dis    = (irq_lvl == IRQ_TEST) || rst_pin_hv;
        end
        PATH_BLANK_HI: begin
          mon_mode = 1'b1;
          cop_dis  = 1'b1;
        end
        PATH_BLANK_LO: begin
          mon_mode = 1'b1;
          pll_en   = 1'b1;
          cop_dis  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R3: bypass only with the divide-by-two setting and the PLL off
  p_bypass_div2_r3: assert property (@(posedge clk) disable iff (!por_n)
    osc_bypass |-> (!bus_div4 && !pll_en));

  // R5: the PLL runs only inside monitor mode
  p_pll_in_mon_r5: assert property (@(posedge clk) disable iff (!por_n)
    pll_en |-> mon_mode);

  // R9: once given on a blank path, the watchdog disable is kept
  p_cop_kept_r9: assert property (@(posedge clk) disable iff (!por_n)
    ($past(cop_dis) && $past(sampled) && path_is_blank(path_q)) |-> cop_dis);

  // R8: the extra reset only on the blank-vector paths
  p_req_blank_only_r8: assert property (@(posedge clk) disable iff (!por_n)
    extra_rst_req |-> path_is_blank(path_q));

  // R7: nothing leaves the default state before latching
  p_idle_before_latch_r7: assert property (@(posedge clk) disable iff (!por_n)
    !sampled |-> (!mon_mode && !extra_rst_req && !cop_dis));

endmodule

// File: tb/mon_entry_ctrl_bench.sv
module mon_entry_ctrl_bench;
  import mon_entry_pkg::*;

  localparam int VW = 8;
  localparam int PC = 3;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic [1:0]    irq_lvl = 2'b01;
  logic          rst_pin_hv = 1'b0;
  logic          ptc3 = 1'b0;
  logic [VW-1:0] vec_hi = 8'hFF;
  logic [VW-1:0] vec_lo = 8'hFF;
  logic mon_mode, pll_en, osc_bypass, bus_div4, cop_dis, extra_rst_req;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  mon_entry_ctrl #(.VEC_W(VW), .PULSE_CYCLES(PC)) u_mon_entry_ctrl (
    .clk(clk), .por_n(por_n), .irq_lvl(irq_lvl), .rst_pin_hv(rst_pin_hv),
    .ptc3(ptc3), .vec_hi(vec_hi), .vec_lo(vec_lo), .mon_mode(mon_mode),
    .pll_en(pll_en), .osc_bypass(osc_bypass), .bus_div4(bus_div4),
    .cop_dis(cop_dis), .extra_rst_req(extra_rst_req)
  );

  // behavioural reference: 0 none, 1 test, 2 blank/high, 3 blank/low
  int m_edges = 0;
  int m_path = 0;
  bit m_ptc3 = 1'b0;

  function automatic int ref_path(logic [1:0] lvl, logic [7:0] h, logic [7:0] l);
    if (lvl == 2'b10) return 1;
    if (h == 8'hFF && l == 8'hFF) return (lvl == 2'b00) ? 3 : 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!por_n) m_edges = 0;
    else if (m_edges < 100000) m_edges++;
    if (por_n && m_edges == 3) begin
      m_path = ref_path(irq_lvl, vec_hi, vec_lo);
      m_ptc3 = ptc3;
    end
  end

  task automatic chk(string tag, string name, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit valid;
    bit e_mon, e_pll, e_byp, e_div, e_cop, e_req;
    string tg, tc;
    cycles++;
    valid = por_n && m_edges >= 3;
    e_mon = 0; e_pll = 0; e_byp = 0; e_div = 1; e_cop = 0; e_req = 0;
    tg = valid ? "R6" : "R7";
    tc = valid ? "R6" : "R7";
    if (valid) begin
      case (m_path)
        1: begin
          e_mon = 1; e_byp = !m_ptc3; e_div = m_ptc3;
          e_cop = (irq_lvl == 2'b10) || rst_pin_hv; tg = "R3"; tc = "R10";
        end
        2: begin e_mon = 1; e_cop = 1; tg = "R4"; tc = "R9"; end
        3: begin e_mon = 1; e_pll = 1; e_cop = 1; tg = "R5"; tc = "R9"; end
        default: ;
      endcase
      e_req = (m_path >= 2) && (m_edges < 3 + PC);
    end
    chk((m_path == 1 && valid) ? "R2" : tg, "mon_mode", mon_mode, e_mon);
    chk(tg, "pll_en", pll_en, e_pll);
    chk(tg, "osc_bypass", osc_bypass, e_byp);
    chk(tg, "bus_div4", bus_div4, e_div);
    chk(tc, "cop_dis", cop_dis, e_cop);
    chk("R8", "extra_rst_req", extra_rst_req, e_req);
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic session(string tag, logic [1:0] lvl, logic p3,
                         logic [7:0] h, logic [7:0] l, logic exp_mon);
    step(1);
    por_n = 1'b0;
    irq_lvl = lvl; ptc3 = p3; vec_hi = h; vec_lo = l; rst_pin_hv = 1'b0;
    step(3);
    por_n = 1'b1;
    step(5);
    @(negedge clk);
    chk(tag, "mon_mode after entry", mon_mode, exp_mon);
    step(1);
    // R7: perturb every entry input after latching
    irq_lvl = (lvl == 2'b00) ? 2'b01 : 2'b00;
    ptc3 = !p3; vec_hi = ~h; vec_lo = 8'h00;
    step(4);
    rst_pin_hv = 1'b1;
    step(2);
    rst_pin_hv = 1'b0; irq_lvl = 2'b10;
    step(2);
    irq_lvl = 2'b11;
    step(2);
    irq_lvl = 2'b00;
    step(2);
  endtask

  initial begin
    step(2);
    @(negedge clk);
    chk("R7", "mon_mode in reset", mon_mode, 1'b0);
    chk("R7", "bus_div4 in reset", bus_div4, 1'b1);
    session("R2", 2'b10, 1'b0, 8'h12, 8'h34, 1'b1);
    session("R3", 2'b10, 1'b1, 8'h12, 8'h34, 1'b1);
    session("R2", 2'b10, 1'b1, 8'hFF, 8'hFF, 1'b1);
    session("R4", 2'b01, 1'b0, 8'hFF, 8'hFF, 1'b1);
    session("R4", 2'b11, 1'b1, 8'hFF, 8'hFF, 1'b1);
    session("R5", 2'b00, 1'b1, 8'hFF, 8'hFF, 1'b1);
    session("R5", 2'b00, 1'b0, 8'hFF, 8'hFF, 1'b1);
    session("R6", 2'b01, 1'b0, 8'h00, 8'h00, 1'b0);
    session("R1", 2'b00, 1'b0, 8'hFF, 8'hFE, 1'b0);
    session("R1", 2'b01, 1'b1, 8'h7F, 8'hFF, 1'b0);
    // R7: por released during the clock cycle, held back by the synchronizer
    step(1);
    por_n = 1'b0; irq_lvl = 2'b00; vec_hi = 8'hFF; vec_lo = 8'hFF;
    step(2);
    por_n = 1'b1;
    @(negedge clk);
    chk("R7", "mon_mode before latch", mon_mode, 1'b0);
    step(8);
    @(negedge clk);
    chk("R8", "request ended", extra_rst_req, 1'b0);
    chk("R9", "cop_dis held", cop_dis, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule